// File: doc/BRIEF.md
# Pin-Change Interrupt Flag Unit

This block turns activity on eight input pins into latched interrupt flags and one combined request line. Each pin goes through a synchronizer. The unit compares the synchronized value with its value one clock earlier, and a transition in the direction chosen for that pin sets the pin's flag. A flag stays set until it is cleared in one of two ways:

- software writes a 0 to the flag bit, or
- an external sequencer acknowledges that pin by index.

The request line is high when the global enable input is high and at least one flag is set whose enable bit is also set. Flags latch whatever their enable bits are. The enable only gates the request, so a flag that was pending before its enable was turned on raises the request as soon as the enable is written. Only edges are detected; a steady level never sets a flag.

Register map (2-bit address):

| Address | Register | Write behaviour | Read behaviour |
|---|---|---|---|
| 0 | Edge select | stores the value; bit 1 = falling edge, 0 = rising edge | returns the stored value |
| 1 | Enable | stores the value | returns the stored value |
| 2 | Flags | each bit written 0 clears that flag; each bit written 1 leaves it unchanged | returns the flags |
| 3 | Unused | ignored | returns zero |

Top module: `pinIrqUnit`

## Requirements
- R1: After reset, the edge-select, enable and flag registers read zero and irqReq is 0.
- R2: With edge select bit 0 (rising), a 0-to-1 change on the pin sets its flag. The flag is readable at address 2 no later than the third rising clock edge after the change. A 1-to-0 change does not set it.
- R3: With edge select bit 1 (falling), a 1-to-0 change on the pin sets its flag. A 0-to-1 change does not set it.
- R4: A flag sets even when its enable bit is 0. Writing the enable bit to 1 later raises irqReq with no further pin activity.
- R5: irqReq is 1 exactly when gieIn is 1 and some flag bit and the matching enable bit are both 1.
- R6: A write to address 2 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged.
- R7: ackEn high for one cycle clears the flag selected by ackIdx (pin number 0 to 7) and no other flag.
- R8: When a detected edge and a clear (write or acknowledge) reach the same flag in the same cycle, the flag ends up set.
- R9: Changing a pin's edge-select bit while the pin holds steady does not set its flag.
- R10: An edge on one pin sets only that pin's flag.
- R11: Writes to addresses 0 and 1 store the data, and reads return it. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 8 | Asynchronous pin inputs |
| gieIn | input | 1 | Global interrupt enable |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 8 | Register read data (combinational) |
| ackEn | input | 1 | Acknowledge strobe from the sequencer |
| ackIdx | input | 3 | Pin index to acknowledge |
| irqReq | output | 1 | Combined interrupt request |

## Verification
The bench changes the edge select in the same cycle that the pins move. A design that used the old select, or that compared the raw pin instead of its delayed copy, would set flags for the wrong direction. It also lines a write-zero clear and an acknowledge up with the exact cycle in which an edge is detected. If clear wins over set in that cycle, the edge is lost without trace. Other checks flip a select bit under a steady high pin, which a design that derives edges from the select would misread as an edge. Finally, a flag is left pending before its enable is written, which catches a design that gates the flag input rather than the request output.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;
  localparam int PIN_COUNT  = 8;
  localparam int REG_ADDR_W = 2;
  localparam int PIN_IDX_W  = $clog2(PIN_COUNT);

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_EDGE   = 2'd0,
    REG_ENABLE = 2'd1,
    REG_FLAG   = 2'd2,
    REG_NONE   = 2'd3
  } regSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic                 edgeWr;
    logic                 enableWr;
    logic [PIN_COUNT-1:0] clrMask;
  } ctlStrobe_t;
endpackage

// File: rtl/pinirq_ctrl.sv
module pinirq_ctrl
  import pinirq_pkg::*;
(
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] wrAddr,
  input  logic [PIN_COUNT-1:0]  wrData,
  input  logic                  ackEn,
  input  logic [PIN_IDX_W-1:0]  ackIdx,
  output ctlStrobe_t            strobe
);
  logic flagWr;

  always_comb begin
    strobe.edgeWr   = wrEn && (regSel_e'(wrAddr) == REG_EDGE);
    strobe.enableWr = wrEn && (regSel_e'(wrAddr) == REG_ENABLE);
    flagWr          = wrEn && (regSel_e'(wrAddr) == REG_FLAG);
  end

  // R6, R7: per-pin clear from write-zero or acknowledge
  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_clr
    assign strobe.clrMask[i] = (flagWr && !wrData[i]) ||
                               (ackEn && (ackIdx == PIN_IDX_W'(i)));
  end
endmodule

// File: rtl/pinirq_datapath.sv
module pinirq_datapath
  import pinirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PIN_COUNT-1:0]  pinIn,
  input  logic                  gieIn,
  input  logic [PIN_COUNT-1:0]  wrData,
  input  ctlStrobe_t            strobe,
  input  logic [REG_ADDR_W-1:0] rdAddr,
  output logic [PIN_COUNT-1:0]  rdData,
  output logic                  irqReq,
  output logic [PIN_COUNT-1:0]  flagBits,
  output logic [PIN_COUNT-1:0]  edgeHit
);
  logic [PIN_COUNT-1:0] syncChain [SYNC_STAGES];
  logic [PIN_COUNT-1:0] pinSync, pinPrev;
  logic [PIN_COUNT-1:0] edgeSel, enBits;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncChain[0] <= '0;
        else       syncChain[0] <= pinIn;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncChain[s] <= '0;
        else       syncChain[s] <= syncChain[s-1];
    end
  end
  assign pinSync = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) pinPrev <= '0;
    else       pinPrev <= pinSync;

  // R2, R3, R9: edge from sampled history only; select picks direction
  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_edge
    assign edgeHit[i] = edgeSel[i] ? (pinPrev[i] && !pinSync[i])
                                   : (!pinPrev[i] && pinSync[i]);
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      edgeSel  <= '0;
      enBits   <= '0;
      flagBits <= '0;
    end else begin
      if (strobe.edgeWr)   edgeSel <= wrData;
      if (strobe.enableWr) enBits  <= wrData;
      // R8: set overrides clear
      flagBits <= (flagBits & ~strobe.clrMask) | edgeHit;
    end

  // R4, R5: enable gates only the request
  assign irqReq = gieIn && |(flagBits & enBits);

  always_comb begin
    case (regSel_e'(rdAddr))
      REG_EDGE:   rdData = edgeSel;
      REG_ENABLE: rdData = enBits;
      REG_FLAG:   rdData = flagBits;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/pinIrqUnit.sv
module pinIrqUnit
  import pinirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PIN_COUNT-1:0]  pinIn,
  input  logic                  gieIn,
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] wrAddr,
  input  logic [PIN_COUNT-1:0]  wrData,
  input  logic [REG_ADDR_W-1:0] rdAddr,
  output logic [PIN_COUNT-1:0]  rdData,
  input  logic                  ackEn,
  input  logic [PIN_IDX_W-1:0]  ackIdx,
  output logic                  irqReq
);
  ctlStrobe_t           strobe;
  logic [PIN_COUNT-1:0] flagBits, edgeHit, clrMask;

  pinirq_ctrl u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ackEn(ackEn), .ackIdx(ackIdx), .strobe(strobe)
  );

  pinirq_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_data (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .gieIn(gieIn),
    .wrData(wrData), .strobe(strobe), .rdAddr(rdAddr),
    .rdData(rdData), .irqReq(irqReq),
    .flagBits(flagBits), .edgeHit(edgeHit)
  );

  assign clrMask = strobe.clrMask;
endmodule

// File: rtl/pinirq_checker.sv
module pinirq_checker
  import pinirq_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 gieIn,
  input logic                 irqReq,
  input logic                 ackEn,
  input logic [PIN_IDX_W-1:0] ackIdx,
  input logic [PIN_COUNT-1:0] flagBits,
  input logic [PIN_COUNT-1:0] edgeHit,
  input logic [PIN_COUNT-1:0] clrMask
);
  p_req_needs_gie_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> gieIn);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(edgeHit) & ~flagBits) == '0));

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(flagBits) & ~flagBits & ~$past(clrMask)) == '0));

  p_no_spurious_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flagBits & ~$past(flagBits) & ~$past(edgeHit)) == '0));

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ackEn && !edgeHit[ackIdx]) |=> !flagBits[$past(ackIdx)]);
endmodule

bind pinIrqUnit pinirq_checker u_chk (
  .clk(clk), .rstN(rstN), .gieIn(gieIn), .irqReq(irqReq),
  .ackEn(ackEn), .ackIdx(ackIdx), .flagBits(flagBits),
  .edgeHit(edgeHit), .clrMask(clrMask)
);

// File: tb/pinIrqUnit_bench.sv
module pinIrqUnit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_VEC    = 13;

  typedef struct packed {
    logic [7:0] pins;
    logic       wr;
    logic [1:0] addr;
    logic [7:0] data;
    logic       ack;
    logic [2:0] idx;
    logic       gie;
    logic [7:0] expFlags;
    logic       expIrq;
  } vec_t;

  // pins, wr, addr, data, ack, idx, gie, expFlags, expIrq
  localparam vec_t VECS [NUM_VEC] = '{
    '{8'h01, 1'b0, 2'd0, 8'h00, 1'b0, 3'd0, 1'b0, 8'h01, 1'b0}, // R2 R4 rise sets while disabled
    '{8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 3'd0, 1'b0, 8'h01, 1'b0}, // R2 fall ignored
    '{8'h00, 1'b1, 2'd1, 8'h01, 1'b0, 3'd0, 1'b1, 8'h01, 1'b1}, // R4 enable later -> request
    '{8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 3'd0, 1'b0, 8'h01, 1'b0}, // R5 gie low masks
    '{8'hF0, 1'b1, 2'd0, 8'hF0, 1'b0, 3'd0, 1'b0, 8'h01, 1'b0}, // R3 rise ignored on falling pins
    '{8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 3'd0, 1'b0, 8'hF1, 1'b0}, // R3 fall sets
    '{8'h00, 1'b1, 2'd2, 8'h0F, 1'b0, 3'd0, 1'b0, 8'h01, 1'b0}, // R6 write zero clears
    '{8'h00, 1'b0, 2'd0, 8'h00, 1'b1, 3'd0, 1'b1, 8'h00, 1'b0}, // R7 acknowledge clears
    '{8'h02, 1'b0, 2'd0, 8'h00, 1'b0, 3'd0, 1'b1, 8'h02, 1'b0}, // R10 R5 only pin1, masked
    '{8'h02, 1'b1, 2'd1, 8'h02, 1'b0, 3'd0, 1'b1, 8'h02, 1'b1}, // R4 enable pin1
    '{8'h02, 1'b1, 2'd0, 8'hFF, 1'b0, 3'd0, 1'b1, 8'h02, 1'b1}, // R9 select flip, pin steady
    '{8'h00, 1'b1, 2'd2, 8'h00, 1'b0, 3'd0, 1'b1, 8'h02, 1'b1}, // R6 R3 clear then fall resets
    '{8'h00, 1'b1, 2'd2, 8'hFF, 1'b0, 3'd0, 1'b0, 8'h02, 1'b0}  // R6 write ones no effect
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] pinIn = '0;
  logic       gieIn = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       ackEn = 1'b0;
  logic [2:0] ackIdx = '0;
  logic       irqReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinIrqUnit u_pinIrqUnit (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .gieIn(gieIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .ackEn(ackEn), .ackIdx(ackIdx), .irqReq(irqReq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] v);
    rdAddr = a;
    #1 v = rdData;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    readReg(2'd0, v); check("R1 edge", v, 8'h00);
    readReg(2'd1, v); check("R1 enable", v, 8'h00);
    readReg(2'd2, v); check("R1 flags", v, 8'h00);
    check("R1 irq", {7'b0, irqReq}, 8'h00);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int k = 0; k < NUM_VEC; k++) begin
      @(negedge clk);
      pinIn = VECS[k].pins; wrEn = VECS[k].wr; wrAddr = VECS[k].addr;
      wrData = VECS[k].data; ackEn = VECS[k].ack; ackIdx = VECS[k].idx;
      gieIn = VECS[k].gie;
      @(negedge clk);
      wrEn = 1'b0; ackEn = 1'b0;
      repeat (3) @(negedge clk);
      readReg(2'd2, v);
      check($sformatf("vec%0d flags", k), v, VECS[k].expFlags);
      check($sformatf("vec%0d irq", k), {7'b0, irqReq}, {7'b0, VECS[k].expIrq});
    end

    // R11 register readback
    readReg(2'd0, v); check("R11 edge readback", v, 8'hFF);
    readReg(2'd1, v); check("R11 enable readback", v, 8'h02);
    readReg(2'd3, v); check("R11 unused addr", v, 8'h00);

    // R8 acknowledge coincident with detected edge on pin3
    @(negedge clk); wrEn = 1'b1; wrAddr = 2'd0; wrData = 8'h00; // all rising
    @(negedge clk); wrEn = 1'b0; pinIn = 8'h08;
    @(negedge clk);                 // stage 1 loaded
    @(negedge clk); ackEn = 1'b1; ackIdx = 3'd3; // edge visible this cycle
    @(negedge clk); ackEn = 1'b0;
    readReg(2'd2, v); check("R8 ack vs edge", v & 8'h08, 8'h08);

    // R8 write-zero clear coincident with edge on pin4
    @(negedge clk); pinIn = 8'h18;
    @(negedge clk);
    @(negedge clk); wrEn = 1'b1; wrAddr = 2'd2; wrData = 8'h00;
    @(negedge clk); wrEn = 1'b0;
    readReg(2'd2, v); check("R8 write vs edge", v, 8'h10);

    // R7 acknowledge of pin4 leaves other flags
    @(negedge clk); wrEn = 1'b1; wrAddr = 2'd2; wrData = 8'hFF; // no-op
    @(negedge clk); wrEn = 1'b0; ackEn = 1'b1; ackIdx = 3'd4;
    @(negedge clk); ackEn = 1'b0;
    readReg(2'd2, v); check("R7 ack pin4", v, 8'h00);

    finishRun();
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule